// File: doc/BRIEF.md
# Indirect Colour-Grading Table Access Port

This block holds six colour-grading lookup tables in on-chip storage. It lets a byte-wide register bus read and write their entries through four register offsets. The host names a table and an index in two setup registers. It then moves one 16-bit entry as a low byte and a high byte at the two value offsets.

One table maps hue to hue and stores 14-bit signed entries. The other five tables store 12-bit unsigned entries. A write takes effect only when the high byte arrives: the entry is formed from that byte and the low byte written before it. A read of the low byte captures the whole entry, so the high byte read next always belongs to the same entry.

In bulk mode, every access to the low value offset advances the index by one. A host can therefore stream a whole table without rewriting the index between entries.

Top module: `cgrade_port`

## Requirements
- R1: After reset, the switch register and the index register both read back as 0x00.
- R2: The table field selects separate storage. Its codes are 0 hue/hue, 1 hue/saturation, 2 lightness/saturation, 3 saturation/saturation, 4 lightness/lightness and 5 hue/lightness. A write to one table leaves the same index in another table unchanged.
- R3: Table 0 keeps 14 bits per entry, treated as signed. When the high byte is read, its bits 7:6 copy bit 13 of the entry, and written bits 15:14 are dropped.
- R4: Tables 1 to 5 keep 12 bits per entry. When the high byte is read, its bits 7:4 are zero.
- R5: An entry changes only when the high value byte (offset 3) is written. It then takes that byte as bits 15:8 and the last byte written to offset 2 as bits 7:0. A write to offset 2 alone leaves the stored entry unchanged.
- R6: A read of offset 2 returns bits 7:0 of the addressed entry and captures the whole entry. The next read of offset 3 returns bits 15:8 of that captured entry, even if the entry was written in between.
- R7: Only bits 5:0 of the index register address an entry. Switch bits 4:1 and index bits 7:6 are stored but do not change which entry is accessed.
- R8: Bit 0 of the switch register set to 1 selects bulk mode. In bulk mode, each read or write of offset 2 increments index bits 5:0, wrapping from 63 to 0. A following write to offset 3 commits to the index in use at that offset-2 access. With bit 0 cleared, the index does not move.
- R9: Table codes 6 and 7 are reserved. Writes addressed to them change no table, and reads of offsets 2 and 3 return 0x00.
- R10: Offset 0 is the switch register: bits 7:5 table, bits 4:1 upper index, bit 0 bulk mode. Offset 1 is the index register. Both read back what was written. Read data appears on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 2 | Register offset: 0 switch, 1 index, 2 value low, 3 value high |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |

## Verification
Entries go through a narrow table with values above 12 bits, to expose truncation. They also go through the signed table with bit 13 both set and clear, which separates correct sign extension from zero extension. Three patterns pull the commit and latch rules apart: a lone low-byte write, a full write slipped between a low read and its high read, and a pass in bulk mode across index 63. Together they distinguish a commit on the wrong byte, a live read of the high half, and a missing or unwrapped increment. Index and switch values with the unused upper bits set, followed by writes to reserved codes, confirm that those bits and codes reach no storage.

// File: rtl/cgrade_port.sv
module cgrade_port #(
  parameter int IDX_W    = 6,
  parameter int NTAB     = 6,
  parameter int WIDE_W   = 14,
  parameter int NARROW_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [1:0] A_SW = 2'd0, A_IDX = 2'd1, A_LO = 2'd2, A_HI = 2'd3;

  logic [2:0]       tbl, pend_tbl, lat_tbl;
  logic [3:0]       idx_hi;
  logic             bulk;
  logic [7:0]       idx_lo, lo_buf;
  logic [IDX_W-1:0] pend_idx;
  logic [15:0]      latch, rd_word;
  logic [15:0]      tword [NTAB];

  wire [IDX_W-1:0] cur_idx = idx_lo[IDX_W-1:0];
  wire             lo_acc  = (bus_wr || bus_rd) && bus_addr == A_LO;
  wire             commit  = bus_wr && bus_addr == A_HI;
  wire [15:0]      wfull   = {bus_wdata, lo_buf};

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    localparam int W = (t == 0) ? WIDE_W : NARROW_W;
    logic [W-1:0] mem [DEPTH];
    always_ff @(posedge clk)
      if (commit && pend_tbl == 3'(t)) mem[pend_idx] <= wfull[W-1:0];
    if (t == 0) begin : g_signed
      assign tword[t] = {{(16-W){mem[cur_idx][W-1]}}, mem[cur_idx]};
    end else begin : g_unsigned
      assign tword[t] = {{(16-W){1'b0}}, mem[cur_idx]};
    end
  end

  always_comb begin
    rd_word = '0;
    for (int t = 0; t < NTAB; t++)
      if (tbl == 3'(t)) rd_word = tword[t];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbl <= '0; idx_hi <= '0; bulk <= 1'b0; idx_lo <= '0; lo_buf <= '0;
      pend_tbl <= '0; pend_idx <= '0; latch <= '0; lat_tbl <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_SW:    {tbl, idx_hi, bulk} <= bus_wdata;
          A_IDX:   idx_lo <= bus_wdata;
          A_LO:    lo_buf <= bus_wdata;
          default: ;
        endcase
      end
      if (lo_acc) begin
        pend_tbl <= tbl;
        pend_idx <= cur_idx;
        if (bulk) idx_lo[IDX_W-1:0] <= cur_idx + IDX_W'(1);
      end
      if (bus_rd) begin
        case (bus_addr)
          A_SW:  bus_rdata <= {tbl, idx_hi, bulk};
          A_IDX: bus_rdata <= idx_lo;
          A_LO: begin
            bus_rdata <= rd_word[7:0];
            latch     <= rd_word;
            lat_tbl   <= tbl;
          end
          default: bus_rdata <= latch[15:8];
        endcase
      end
    end
  end

  p_idx_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_acc && bulk && (&cur_idx) |=> idx_lo[IDX_W-1:0] == '0);

  p_idx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_acc && !bulk |=> $stable(idx_lo));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == A_LO && tbl >= 3'(NTAB) |=> bus_rdata == 8'h00);

  p_sign_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == A_HI && lat_tbl == 3'd0
    |=> (bus_rdata[7:WIDE_W-9] == '0) || (&bus_rdata[7:WIDE_W-9]));

  p_narrow_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == A_HI && lat_tbl != 3'd0 |=> bus_rdata[7:NARROW_W-8] == '0);
endmodule

// File: tb/cgrade_port_test.sv
module cgrade_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cgrade_port uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
                   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic put(input logic [7:0] sw, input logic [7:0] idx, input logic [15:0] v);
    wr(2'd0, sw); wr(2'd1, idx); wr(2'd2, v[7:0]); wr(2'd3, v[15:8]);
  endtask

  task automatic get(input logic [7:0] sw, input logic [7:0] idx, output logic [15:0] v);
    logic [7:0] l, h;
    wr(2'd0, sw); wr(2'd1, idx); rd(2'd2, l); rd(2'd3, h);
    v = {h, l};
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R1 switch", d, 8'h00);
    rd(2'd1, d); chk("R1 index", d, 8'h00);
  endtask

  task automatic t_widths;
    logic [15:0] v;
    put(8'h20, 8'd5, 16'hFABC); get(8'h20, 8'd5, v);
    chk("R4 lo", v[7:0], 8'hBC); chk("R4 hi", v[15:8], 8'h0A);
    put(8'h00, 8'd7, 16'h2123); get(8'h00, 8'd7, v);
    chk("R3 neg lo", v[7:0], 8'h23); chk("R3 neg hi", v[15:8], 8'hE1);
    put(8'h00, 8'd8, 16'hDF45); get(8'h00, 8'd8, v);
    chk("R3 pos hi", v[15:8], 8'h1F);
  endtask

  task automatic t_isolation;
    logic [15:0] v;
    put(8'h40, 8'd5, 16'h0123); get(8'h20, 8'd5, v);
    chk("R2 other table", v[7:0], 8'hBC);
    get(8'h40, 8'd5, v); chk("R2 own table", v[7:0], 8'h23);
  endtask

  task automatic t_commit;
    logic [15:0] v;
    wr(2'd0, 8'h20); wr(2'd1, 8'd5); wr(2'd2, 8'h55);
    get(8'h20, 8'd5, v);
    chk("R5 lone low lo", v[7:0], 8'hBC); chk("R5 lone low hi", v[15:8], 8'h0A);
  endtask

  task automatic t_latch;
    logic [7:0] l, h;
    wr(2'd0, 8'h20); wr(2'd1, 8'd5); rd(2'd2, l);
    wr(2'd2, 8'h77); wr(2'd3, 8'h07);
    rd(2'd3, h); chk("R6 held hi", h, 8'h0A);
    rd(2'd2, l); rd(2'd3, h);
    chk("R6 new lo", l, 8'h77); chk("R6 new hi", h, 8'h07);
  endtask

  task automatic t_index_bits;
    logic [15:0] v;
    logic [7:0] d;
    get(8'h34, 8'hC5, v);
    chk("R7 lo", v[7:0], 8'h77); chk("R7 hi", v[15:8], 8'h07);
    rd(2'd0, d); chk("R10 switch readback", d, 8'h34);
    rd(2'd1, d); chk("R10 index readback", d, 8'hC5);
    rd(2'd1, d); chk("R8 normal no step", d, 8'hC5);
  endtask

  task automatic t_bulk;
    logic [7:0] d, l, h;
    wr(2'd0, 8'h81); wr(2'd1, 8'd62);
    for (int i = 0; i < 3; i++) begin
      wr(2'd2, 8'h10 + 8'(i)); wr(2'd3, 8'h01);
    end
    rd(2'd1, d); chk("R8 index after wrap", d, 8'd1);
    wr(2'd1, 8'd62);
    for (int i = 0; i < 3; i++) begin
      rd(2'd2, l); rd(2'd3, h);
      chk("R8 bulk lo", l, 8'h10 + 8'(i)); chk("R8 bulk hi", h, 8'h01);
    end
    rd(2'd1, d); chk("R8 index after read", d, 8'd1);
  endtask

  task automatic t_reserved;
    logic [15:0] v;
    put(8'hC0, 8'd5, 16'h0FFF); get(8'hC0, 8'd5, v);
    chk("R9 lo", v[7:0], 8'h00); chk("R9 hi", v[15:8], 8'h00);
    put(8'hE0, 8'd5, 16'h0ABC); get(8'h20, 8'd5, v);
    chk("R9 no side write", v[7:0], 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_widths; t_isolation; t_commit; t_latch;
    t_index_bits; t_bulk; t_reserved;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule